// File: doc/BRIEF.md
# Descriptor-Chained Buffer Mover

This block is a single-channel copy engine driven by a chain of descriptors in system memory. Software sets up the descriptors, programs a pointer to the first one and an initial source address, then sets the channel enable. The engine then handles one buffer per descriptor. For each buffer it fetches the descriptor and copies words from the initial source address to the destination that the descriptor names. When the buffer is finished, it writes a completion record back into that descriptor.

Every buffer restarts from the same programmed source address. Only the destination moves from one descriptor to the next. After each buffer the engine rewrites a single word of the descriptor, the first control word. In that word it sets the completion flag and stores the number of words it moved. Software can poll that word in memory instead of the engine. Two level interrupts report buffer completion and chain completion. Reading the status register clears both interrupts.

Top module: `lld_dma_top`

## Requirements
- R1: Each descriptor is five 32-bit words at pointer P: source (P+0, ignored), destination (P+4), next pointer (P+8), control A (P+12), control B (P+16). All five are read, in ascending address order, before any data moves.
- R2: Every buffer reads its data starting at the programmed initial source address (register 1, low two bits forced to zero) and increments by 4 per word. The source word of the descriptor has no effect.
- R3: Every buffer writes its data starting at the destination word of its own descriptor and increments by 4 per word. Destination word j receives source word j.
- R4: Control A bits [15:0] give the number of words to move. A value of 0 moves no data.
- R5: On buffer completion, exactly one write goes to the descriptor, at P+12. Its value is control A with bit 31 set, bits [30:16] unchanged and bits [15:0] equal to the words moved. The other descriptor words and the word after the destination buffer stay unchanged.
- R6: When bit 0 of control B is clear, the next descriptor is fetched from the next-pointer word. When it is set, that descriptor is the last one and no further descriptor is read.
- R7: The channel starts only when register 2 bit 0 is 1 and register 3 (global enable) bit 0 is 1. The first fetch uses register 0.
- R8: irq_buf rises when any buffer completes. irq_xfer rises when the last buffer completes, and the channel enable (register 2) then reads 0.
- R9: Status register 4 reads bit 0 = buffer complete and bit 1 = chain complete. A read clears both bits, and irq_buf and irq_xfer follow those bits.
- R10: The low two bits of the first pointer and of each next pointer are ignored.
- R11: The memory request holds address, direction and data until mem_ready. At most one request is outstanding, and read data returns with mem_rvalid in a later cycle.
- R12: After reset the interrupts are low, no memory request is made, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (read of index 4 clears status) |
| reg_addr | input | 3 | register index 0..4 |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| mem_req | output | 1 | memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | byte address, word aligned |
| mem_wdata | output | 32 | write data |
| mem_ready | input | 1 | request accepted this cycle |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | 32 | read data |
| irq_buf | output | 1 | buffer-complete interrupt level |
| irq_xfer | output | 1 | chain-complete interrupt level |

## Verification
The hardest case to reach from the ports combines several conditions in one run. A chain must end on a descriptor whose next pointer is still non-zero and points at a well-formed descriptor. Buffer sizes must include zero, the memory must throttle acceptance, and the pointers must carry junk low bits. A buggy engine could mishandle any of these and still leave the copied data correct. The bench sweeps chain length 1 to 3, every starting size 0 to 3 (rotating per descriptor) and two acceptance patterns. For each run it counts reads landing in the descriptor placed after the last one, counts all writes, and compares every descriptor word and the guard word after each destination buffer with values computed from the sweep indices.

// File: rtl/lld_pkg.sv
// Package: shared constants and the sequencer state type for the descriptor mover.
// Assumes 32-bit words and byte addressing with 4-byte word stride.
package lld_pkg;
    localparam int DW          = 32;
    localparam int DESC_WORDS  = 5;
    localparam int IDX_SRC     = 0;
    localparam int IDX_DST     = 1;
    localparam int IDX_NXT     = 2;
    localparam int IDX_CA      = 3;
    localparam int IDX_CB      = 4;
    localparam int CA_DONE_BIT = 31;
    localparam int CB_LAST_BIT = 0;

    localparam logic [2:0] RA_FIRST = 3'd0;
    localparam logic [2:0] RA_SRC   = 3'd1;
    localparam logic [2:0] RA_CHAN  = 3'd2;
    localparam logic [2:0] RA_GLOB  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FREQ  = 3'd1,
        S_FWAIT = 3'd2,
        S_SETUP = 3'd3,
        S_RREQ  = 3'd4,
        S_RWAIT = 3'd5,
        S_WREQ  = 3'd6,
        S_WB    = 3'd7
    } seq_state_t;
endpackage

// File: rtl/lld_regs.sv
// Module: register file of the mover. It holds the first pointer, the initial
// source, the channel and global enables, and the clear-on-read status.
// Assumes: the sequencer pulses buf_done_i / chain_done_i for one cycle each.
// A status set in the same cycle as a clearing read wins over the clear.
module lld_regs
    import lld_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          buf_done_i,
    input  logic          chain_done_i,
    output logic [AW-1:0] first_ptr_o,
    output logic [AW-1:0] src_init_o,
    output logic          start_ok_o,
    output logic          irq_buf_o,
    output logic          irq_xfer_o
);
    logic [AW-1:0] first_q, src_q;
    logic          chan_q, glob_q, buf_q, xfer_q;
    logic          stat_rd;

    assign stat_rd = reg_rd && (reg_addr == RA_STAT);

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            src_q   <= '0;
            glob_q  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == RA_FIRST) first_q <= reg_wdata[AW-1:0];
            if (reg_addr == RA_SRC)   src_q   <= reg_wdata[AW-1:0];
            if (reg_addr == RA_GLOB)  glob_q  <= reg_wdata[0];
        end
    end

    // Channel enable: software sets it; the end of the chain clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_q <= 1'b0;
        else if (chain_done_i)
            chan_q <= 1'b0;
        else if (reg_wr && reg_addr == RA_CHAN)
            chan_q <= reg_wdata[0];
    end

    // Status bits: set by completion pulses, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= 1'b0;
            xfer_q <= 1'b0;
        end else begin
            buf_q  <= buf_done_i   | (buf_q  & ~stat_rd);
            xfer_q <= chain_done_i | (xfer_q & ~stat_rd);
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_FIRST: reg_rdata[AW-1:0] = first_q;
            RA_SRC:   reg_rdata[AW-1:0] = src_q;
            RA_CHAN:  reg_rdata[0]      = chan_q;
            RA_GLOB:  reg_rdata[0]      = glob_q;
            RA_STAT:  reg_rdata[1:0]    = {xfer_q, buf_q};
            default:  reg_rdata         = '0;
        endcase
    end

    assign first_ptr_o = first_q;
    assign src_init_o  = src_q;
    assign start_ok_o  = chan_q & glob_q;
    assign irq_buf_o   = buf_q;
    assign irq_xfer_o  = xfer_q;

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !buf_done_i && !chain_done_i) |=> (!buf_q && !xfer_q));
    p_chan_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_q) |-> !chan_q);
endmodule

// File: rtl/lld_desc_store.sv
// Module: holds the descriptor words as they arrive from memory.
// Assumes: one word is written per strobe, at index wr_idx. The source word is
// never kept, because the engine ignores it; its slot reads as zero.
module lld_desc_store
    import lld_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_idx,
    input  logic [DW-1:0]                   wr_data,
    output logic [DESC_WORDS-1:0][DW-1:0]   words_o
);
    for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
        if (i == IDX_SRC) begin : g_drop
            assign words_o[i] = '0;
        end else begin : g_keep
            // Capture word i when it is the one being fetched.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words_o[i] <= '0;
                else if (wr_en && wr_idx == 3'(i))
                    words_o[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/lld_seq.sv
// Module: the chain walker. It fetches a descriptor, moves the buffer word by
// word, writes back control A, then follows the chain or stops.
// Assumes: mem_ready accepts the request in the cycle it is high. Read data
// returns with mem_rvalid in a later cycle. Only one request is in flight.
module lld_seq
    import lld_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SIZE_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_ok,
    input  logic [AW-1:0]                 first_ptr,
    input  logic [AW-1:0]                 src_init,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [DW-1:0]                 mem_wdata,
    input  logic                          mem_ready,
    input  logic                          mem_rvalid,
    input  logic [DW-1:0]                 mem_rdata,
    output logic                          desc_we,
    output logic [2:0]                    desc_idx,
    input  logic [DESC_WORDS-1:0][DW-1:0] desc,
    output logic                          buf_done,
    output logic                          chain_done
);
    localparam int          MID_W = CA_DONE_BIT - SIZE_W;
    localparam logic [2:0]  LAST_IDX = 3'(DESC_WORDS - 1);

    seq_state_t        state;
    logic [AW-1:0]     ptr, src, dst;
    logic [2:0]        idx;
    logic [SIZE_W-1:0] cnt, size, cnt_nxt;
    logic [DW-1:0]     dbuf;
    logic              is_last;
    logic              unused_bits;

    assign size    = desc[IDX_CA][SIZE_W-1:0];
    assign is_last = desc[IDX_CB][CB_LAST_BIT];
    assign cnt_nxt = cnt + 1'b1;
    assign unused_bits = ^{desc[IDX_SRC], desc[IDX_CB], desc[IDX_NXT][1:0],
                           desc[IDX_CA][CA_DONE_BIT], first_ptr[1:0], src_init[1:0]};

    // State, pointers and counters of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ptr   <= '0;
            src   <= '0;
            dst   <= '0;
            idx   <= '0;
            cnt   <= '0;
            dbuf  <= '0;
        end else begin
            case (state)
                S_IDLE: if (start_ok) begin
                    ptr   <= {first_ptr[AW-1:2], 2'b00};
                    idx   <= '0;
                    state <= S_FREQ;
                end
                S_FREQ: if (mem_ready) state <= S_FWAIT;
                S_FWAIT: if (mem_rvalid) begin
                    if (idx == LAST_IDX) begin
                        state <= S_SETUP;
                    end else begin
                        idx   <= idx + 3'd1;
                        state <= S_FREQ;
                    end
                end
                S_SETUP: begin
                    src   <= {src_init[AW-1:2], 2'b00};
                    dst   <= {desc[IDX_DST][AW-1:2], 2'b00};
                    cnt   <= '0;
                    state <= (size == '0) ? S_WB : S_RREQ;
                end
                S_RREQ: if (mem_ready) state <= S_RWAIT;
                S_RWAIT: if (mem_rvalid) begin
                    dbuf  <= mem_rdata;
                    state <= S_WREQ;
                end
                S_WREQ: if (mem_ready) begin
                    cnt   <= cnt_nxt;
                    src   <= src + AW'(4);
                    dst   <= dst + AW'(4);
                    state <= (cnt_nxt == size) ? S_WB : S_RREQ;
                end
                S_WB: if (mem_ready) begin
                    if (is_last) begin
                        state <= S_IDLE;
                    end else begin
                        ptr   <= {desc[IDX_NXT][AW-1:2], 2'b00};
                        idx   <= '0;
                        state <= S_FREQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_FREQ: begin
                mem_req  = 1'b1;
                mem_addr = ptr + {{(AW-5){1'b0}}, idx, 2'b00};
            end
            S_RREQ: begin
                mem_req  = 1'b1;
                mem_addr = src;
            end
            S_WREQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst;
                mem_wdata = dbuf;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + AW'(4 * IDX_CA);
                mem_wdata = {1'b1, desc[IDX_CA][CA_DONE_BIT-1 -: MID_W], cnt};
            end
            default: ;
        endcase
    end

    assign desc_we    = (state == S_FWAIT) && mem_rvalid;
    assign desc_idx   = idx;
    assign buf_done   = (state == S_WB) && mem_ready;
    assign chain_done = buf_done && is_last;

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));
    p_idle_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start_ok) |=> (state == S_IDLE));
    p_wb_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB) |-> (cnt == size));
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/lld_dma_top.sv
// Module: top of the descriptor-chained buffer mover. It wires the register
// file, the descriptor store and the chain walker together.
// Assumes: a single-master memory with a valid/ready request handshake and a
// separate read-data valid strobe.
module lld_dma_top
    import lld_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SIZE_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          irq_buf,
    output logic          irq_xfer
);
    logic [AW-1:0]                 first_ptr, src_init;
    logic                          start_ok, buf_done, chain_done, desc_we;
    logic [2:0]                    desc_idx;
    logic [DESC_WORDS-1:0][DW-1:0] desc;

    lld_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .buf_done_i   (buf_done),
        .chain_done_i (chain_done),
        .first_ptr_o  (first_ptr),
        .src_init_o   (src_init),
        .start_ok_o   (start_ok),
        .irq_buf_o    (irq_buf),
        .irq_xfer_o   (irq_xfer)
    );

    lld_desc_store u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (desc_we),
        .wr_idx  (desc_idx),
        .wr_data (mem_rdata),
        .words_o (desc)
    );

    lld_seq #(.AW(AW), .SIZE_W(SIZE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .first_ptr  (first_ptr),
        .src_init   (src_init),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .desc_we    (desc_we),
        .desc_idx   (desc_idx),
        .desc       (desc),
        .buf_done   (buf_done),
        .chain_done (chain_done)
    );

    p_xfer_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_xfer) |-> irq_buf);
endmodule

// File: tb/tb_lld_dma_top.sv
module tb_lld_dma_top;
    localparam int CLK_PERIOD = 10;
    localparam int DBASE = 32'h100;
    localparam int SBASE = 32'h400;
    localparam int OBASE = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        irq_buf, irq_xfer;

    int checks = 0, errors = 0, cycles = 0;
    int n_rd = 0, n_wr = 0, n_junk = 0, n_viol = 0, n_req_seen = 0;
    int junk_lo = 0, first_rd = -1;
    bit stall = 0, rd_pend = 0;
    logic [31:0] mem [0:1023];

    lld_dma_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Acceptance pattern: always ready, or ready every other cycle.
    always @(posedge clk) mem_ready <= stall ? ~mem_ready : 1'b1;

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rvalid) rd_pend = 0;
        if (mem_req) n_req_seen++;
        if (mem_req && mem_ready) begin
            if (rd_pend) n_viol++;
            if (mem_we) begin
                mem[mem_addr[11:2]] = mem_wdata;
                n_wr++;
            end else begin
                mem_rdata  <= mem[mem_addr[11:2]];
                mem_rvalid <= 1'b1;
                rd_pend = 1;
                n_rd++;
                if (first_rd < 0) first_rd = int'(mem_addr);
                if (int'(mem_addr) >= junk_lo && int'(mem_addr) < SBASE) n_junk++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic int sz_of(int base, int k);
        return (base + k) % 4;
    endfunction

    // One chain: nd descriptors, sizes rotate from base, run index r.
    task automatic run_chain(input int nd, input int base, input int r);
        logic [31:0] v;
        int lowb, tot, guard;
        lowb = r % 4;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + i;
        for (int j = 0; j < 4; j++) mem[(SBASE >> 2) + j] = 32'h5A00_0000 + r * 256 + j;
        for (int k = 0; k <= nd; k++) begin
            int p = (DBASE + k * 32) >> 2;
            mem[p + 0] = 32'hFFFF_FFF0;
            mem[p + 1] = OBASE + k * 64;
            mem[p + 2] = DBASE + (k + 1) * 32 + lowb;
            mem[p + 3] = {1'b0, 15'h1234, 16'(sz_of(base, k))};
            mem[p + 4] = (k == nd - 1 || k == nd) ? 32'hFFFF_FF01 : 32'hFFFF_FF00;
        end
        junk_lo = DBASE + nd * 32;
        n_rd = 0; n_wr = 0; n_junk = 0; first_rd = -1;
        wr_reg(3'd0, DBASE + lowb);
        wr_reg(3'd1, SBASE + (r % 2) * 2);
        rd_reg(3'd4, v);
        wr_reg(3'd2, 32'h1);
        guard = 0;
        while (!irq_xfer && guard < 3000) begin @(negedge clk); guard++; end
        repeat (4) @(negedge clk);
        chk("R8 irq_xfer", {31'b0, irq_xfer}, 32'h1);
        chk("R8 irq_buf", {31'b0, irq_buf}, 32'h1);
        rd_reg(3'd2, v); chk("R8 chan enable cleared", v, 32'h0);
        chk("R1 R10 first fetch address", first_rd, DBASE);
        tot = 0;
        for (int k = 0; k < nd; k++) tot += sz_of(base, k);
        chk("R1 R4 read count", n_rd, nd * 5 + tot);
        chk("R5 write count", n_wr, nd + tot);
        chk("R6 no fetch past last", n_junk, 0);
        chk("R11 single outstanding", n_viol, 0);
        for (int k = 0; k < nd; k++) begin
            int p = (DBASE + k * 32) >> 2;
            int s = sz_of(base, k);
            int ob = (OBASE + k * 64) >> 2;
            for (int j = 0; j < s; j++)
                chk("R2 R3 copied word", mem[ob + j], 32'h5A00_0000 + r * 256 + j);
            chk("R5 guard after buffer", mem[ob + s], 32'hDEAD_0000 + ob + s);
            chk("R5 control A written back", mem[p + 3], {1'b1, 15'h1234, 16'(s)});
            chk("R5 source word untouched", mem[p + 0], 32'hFFFF_FFF0);
            chk("R5 next word untouched", mem[p + 2], DBASE + (k + 1) * 32 + lowb);
        end
        chk("R6 junk descriptor untouched", mem[(junk_lo >> 2) + 3],
            {1'b0, 15'h1234, 16'(sz_of(base, nd))});
        rd_reg(3'd4, v); chk("R9 status bits", v, 32'h3);
        #1;
        chk("R9 irq after clear", {30'b0, irq_xfer, irq_buf}, 32'h0);
        rd_reg(3'd4, v); chk("R9 status after clear", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        int run;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state.
        chk("R12 irq_buf", {31'b0, irq_buf}, 32'h0);
        chk("R12 irq_xfer", {31'b0, irq_xfer}, 32'h0);
        chk("R12 mem_req", {31'b0, mem_req}, 32'h0);
        for (int a = 0; a < 5; a++) begin
            rd_reg(3'(a), v); chk("R12 register reset", v, 32'h0);
        end
        // R7: channel enable alone must not start.
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        wr_reg(3'd0, DBASE);
        wr_reg(3'd2, 32'h1);
        n_req_seen = 0;
        repeat (40) @(negedge clk);
        chk("R7 no start without global", n_req_seen, 0);
        wr_reg(3'd2, 32'h0);
        wr_reg(3'd3, 32'h1);
        repeat (20) @(negedge clk);
        chk("R7 no start without channel", n_req_seen, 0);
        run = 0;
        for (int sm = 0; sm < 2; sm++) begin
            stall = sm[0];
            for (int nd = 1; nd <= 3; nd++)
                for (int b = 0; b < 4; b++) begin
                    run_chain(nd, b, run);
                    run++;
                end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule